// File: doc/BRIEF.md
# Speculative Virtual-Channel and Switch Allocator

This block is the resource allocator for the input stage of a virtual-channel router with NPORT ports and NVC virtual channels per port. Every input VC that has a flit at its head presents a bid. The bid carries the output port chosen by route computation, a flag that says whether the packet already owns an output VC, the VC it owns, and a tail marker. Output-VC allocation and switch allocation are both resolved in the same cycle that the bids arrive.

A head flit with no output VC yet does not wait for VC allocation to finish before it asks for the switch. It bids for the switch speculatively, in parallel with its VC request. Its switch win is kept only if it also wins an output VC in that cycle. Otherwise the crossbar slot goes unused and the flit must try again.

Flits that already own an output VC bid firmly. Firm bids win over speculative bids when both contend. The allocator keeps a busy map of the output VCs. A VC becomes busy when it is granted, and it becomes free again when the tail flit of its packet crosses the switch.

Top module: `spec_vc_sw_alloc`

## Requirements
- R1: An input VC bids only while both its flit-valid and route-valid inputs are 1. Without both it receives no VC grant and no switch grant.
- R2: VC grants, switch grants and crossbar grants are all produced combinationally in the same cycle as the bids.
- R3: A speculative bid (has_vc=0) keeps its switch grant only if it wins an output VC in the same cycle. A dropped win leaves that output port with no crossbar grant in that cycle.
- R4: A speculative bid that gets no VC leaves no trace. The free map is unchanged, and the same bid presented in a later cycle is evaluated afresh and can win both grants.
- R5: Firm bids (has_vc=1) win over speculative bids, both at each output port and when the input port picks which of its VCs may bid.
- R6: A firm bid never receives a VC grant and never changes the free map unless it is a tail. Its tail releases VC in_held_vc of its output port.
- R7: Within one priority class, each input port and each output port rotates round-robin. A pointer advances past the winner only when that grant is kept, so a dropped speculative win does not advance it.
- R8: Output VC j of output port o is reported on ovc_free bit o*NVC+j. After reset all bits are 1. A granted VC reads 0 from the next cycle on, and it reads 1 again from the cycle after its tail flit is switched. A single-flit packet (head and tail together) leaves its VC free.
- R9: In each cycle each output port grants at most one input port, and each input port receives at most one switch grant.
- R10: Each output port grants at most one new VC per cycle, and it grants the lowest-numbered free VC, reported on vc_gnt_id. When no VC of the port is free, no VC is granted.
- R11: Input VC v of input port p has index i = p*NVC+v in every per-VC port. xb_sel field o carries the input port number that drives output o, and it is valid while xb_vld[o] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_flit_vld | input | NPORT*NVC | A flit is waiting at the head of input VC i |
| in_route_vld | input | NPORT*NVC | The route of that flit has been computed |
| in_out_port | input | NPORT*NVC*PW | Output port requested by each input VC |
| in_has_vc | input | NPORT*NVC | The packet already owns an output VC (firm bid) |
| in_held_vc | input | NPORT*NVC*VW | The output VC that is owned, meaningful when in_has_vc=1 |
| in_tail | input | NPORT*NVC | The flit is the last one of its packet |
| vc_gnt | output | NPORT*NVC | An output VC was granted to input VC i |
| vc_gnt_id | output | NPORT*NVC*VW | Number of the granted VC within its output port |
| sw_gnt | output | NPORT*NVC | A kept switch grant for input VC i |
| xb_vld | output | NPORT | The crossbar output port is driven this cycle |
| xb_sel | output | NPORT*PW | Input port that drives each crossbar output |
| ovc_free | output | NPORT*NVC | Free map of the output VCs |

## Verification
All grant outputs (vc_gnt, vc_gnt_id, sw_gnt, xb_vld, xb_sel) are due in the cycle the bids are applied, with no register in the path. The free map and the round-robin pointers change at the next rising edge. The bench applies bids just after a falling edge and samples the grants 4 ns later, before the rising edge that commits them. It reads ovc_free one cycle later, after that edge has passed. Pointer effects are checked by repeating bids over consecutive cycles and predicting each winner from the rotation order since reset.

// File: rtl/spec_alloc_pkg.sv
// Shared helpers for the speculative allocator.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package spec_alloc_pkg;

    // Index width for n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Class of a bid presented by one input VC.
    typedef enum logic [1:0] {
        BID_NONE = 2'd0,
        BID_SPEC = 2'd1,
        BID_FIRM = 2'd2
    } bid_e;

endpackage

// File: rtl/cls_rr_arb.sv
// Two-class round-robin arbiter.
// High-class requests always beat low-class ones. Inside the winning class
// the search starts at the pointer. The pointer moves past the winner only
// when the caller asserts advance, so a grant the caller discards leaves it.
module cls_rr_arb
    import spec_alloc_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = idx_w(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_hi,
    input  logic [N-1:0]  req_lo,
    input  logic          advance,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] ptr_q;
    logic [N-1:0]  pool;

    // Pick the first requester of the active class at or after the pointer.
    always_comb begin
        pool    = (|req_hi) ? req_hi : req_lo;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!gnt_vld && pool[(int'(ptr_q) + k) % N]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'((int'(ptr_q) + k) % N);
            end
        end
    end

    // Move the pointer past a grant the caller decided to keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && gnt_vld) begin
            ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : IW'(int'(gnt_idx) + 1);
        end
    end

    p_grant_is_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (req_hi[gnt_idx] || req_lo[gnt_idx]));

    p_high_class_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_hi) |-> (gnt_vld && req_hi[gnt_idx]));

endmodule

// File: rtl/ovc_alloc.sv
// Output-VC allocator with busy map.
// Each output port grants at most one head per cycle and hands out the
// lowest-numbered free VC. Granted VCs become busy and are released by
// release_mask, which the caller raises when a tail crosses the switch.
// A VC claimed and released in the same cycle stays free.
module ovc_alloc
    import spec_alloc_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    localparam int N    = NPORT * NVC,
    localparam int PW   = idx_w(NPORT),
    localparam int VW   = idx_w(NVC),
    localparam int NW   = idx_w(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    head_req,
    input  logic [N*PW-1:0] head_port,
    input  logic [N-1:0]    release_mask,
    output logic [N-1:0]    vc_gnt,
    output logic [N*VW-1:0] vc_gnt_id,
    output logic [N-1:0]    free_mask
);

    logic [N-1:0]  busy_q;
    logic [N-1:0]  claim;
    logic [N-1:0]  port_req [NPORT];
    logic          any_free [NPORT];
    logic [VW-1:0] pick     [NPORT];
    logic          arb_vld  [NPORT];
    logic [NW-1:0] arb_idx  [NPORT];

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        // Find the lowest free VC of this port and gather the heads that want it.
        always_comb begin
            any_free[o] = 1'b0;
            pick[o]     = '0;
            for (int v = NVC - 1; v >= 0; v--) begin
                if (!busy_q[o*NVC + v]) begin
                    any_free[o] = 1'b1;
                    pick[o]     = VW'(v);
                end
            end
            for (int i = 0; i < N; i++) begin
                port_req[o][i] = head_req[i] && any_free[o]
                               && (int'(head_port[i*PW +: PW]) == o);
            end
        end

        cls_rr_arb #(.N(N)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_hi  (port_req[o]),
            .req_lo  ({N{1'b0}}),
            .advance (1'b1),
            .gnt_vld (arb_vld[o]),
            .gnt_idx (arb_idx[o])
        );
    end

    // Spread the per-port winners over the per-input-VC grant outputs.
    always_comb begin
        vc_gnt    = '0;
        vc_gnt_id = '0;
        claim     = '0;
        for (int o = 0; o < NPORT; o++) begin
            if (arb_vld[o]) begin
                vc_gnt[arb_idx[o]]                        = 1'b1;
                vc_gnt_id[int'(arb_idx[o])*VW +: VW]      = pick[o];
                claim[o*NVC + int'(pick[o])]              = 1'b1;
            end
        end
    end

    // Mark claimed VCs busy and free those whose tail left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q | claim) & ~release_mask;
        end
    end

    assign free_mask = ~busy_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_grant_needs_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
            vc_gnt[i] |-> head_req[i]);
    end

endmodule

// File: rtl/sw_alloc.sv
// Separable switch allocator, input stage first.
// Each input port picks one of its VCs, with firm bids ahead of speculative
// ones. Each output port then picks one input port, again firm first. The
// result is tentative; the caller decides which grants are kept and feeds
// that back so only kept grants move the round-robin pointers.
module sw_alloc
    import spec_alloc_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    localparam int N    = NPORT * NVC,
    localparam int PW   = idx_w(NPORT),
    localparam int VW   = idx_w(NVC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    firm,
    input  logic [N-1:0]    spec,
    input  logic [N*PW-1:0] dest,
    input  logic [NPORT-1:0] adv_in,
    input  logic [NPORT-1:0] adv_out,
    output logic [N-1:0]    tent
);

    logic          in_vld  [NPORT];
    logic [VW-1:0] in_idx  [NPORT];
    logic          in_hi   [NPORT];
    logic [PW-1:0] in_dst  [NPORT];
    logic [NPORT-1:0] o_hi [NPORT];
    logic [NPORT-1:0] o_lo [NPORT];
    logic          out_vld [NPORT];
    logic [PW-1:0] out_idx [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        cls_rr_arb #(.N(NVC)) u_in_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_hi  (firm[p*NVC +: NVC]),
            .req_lo  (spec[p*NVC +: NVC]),
            .advance (adv_in[p]),
            .gnt_vld (in_vld[p]),
            .gnt_idx (in_idx[p])
        );

        // Carry the class and destination of this port's chosen VC forward.
        always_comb begin
            in_hi[p]  = |firm[p*NVC +: NVC];
            in_dst[p] = dest[(p*NVC + int'(in_idx[p]))*PW +: PW];
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        // Sort the input-stage winners aimed at this output by class.
        always_comb begin
            for (int p = 0; p < NPORT; p++) begin
                o_hi[o][p] = in_vld[p] &&  in_hi[p] && (int'(in_dst[p]) == o);
                o_lo[o][p] = in_vld[p] && !in_hi[p] && (int'(in_dst[p]) == o);
            end
        end

        cls_rr_arb #(.N(NPORT)) u_out_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_hi  (o_hi[o]),
            .req_lo  (o_lo[o]),
            .advance (adv_out[o]),
            .gnt_vld (out_vld[o]),
            .gnt_idx (out_idx[o])
        );
    end

    // A VC wins tentatively when its input pick is also chosen by its output.
    always_comb begin
        tent = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (in_vld[p] && out_vld[in_dst[p]] && (int'(out_idx[in_dst[p]]) == p)) begin
                tent[p*NVC + int'(in_idx[p])] = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        p_one_pick_per_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(tent[p*NVC +: NVC]));
    end

endmodule

// File: rtl/spec_vc_sw_alloc.sv
// Speculative VC and switch allocator, top level.
// Classifies each input VC's bid, runs VC allocation and switch allocation
// side by side, keeps a speculative switch win only when the same VC also
// won an output VC, and frees output VCs when tails are switched.
// Assumes the input unit holds a bid steady until it is granted.
module spec_vc_sw_alloc
    import spec_alloc_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    localparam int N    = NPORT * NVC,
    localparam int PW   = idx_w(NPORT),
    localparam int VW   = idx_w(NVC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      in_flit_vld,
    input  logic [N-1:0]      in_route_vld,
    input  logic [N*PW-1:0]   in_out_port,
    input  logic [N-1:0]      in_has_vc,
    input  logic [N*VW-1:0]   in_held_vc,
    input  logic [N-1:0]      in_tail,
    output logic [N-1:0]      vc_gnt,
    output logic [N*VW-1:0]   vc_gnt_id,
    output logic [N-1:0]      sw_gnt,
    output logic [NPORT-1:0]  xb_vld,
    output logic [NPORT*PW-1:0] xb_sel,
    output logic [N-1:0]      ovc_free
);

    bid_e             bid [N];
    logic [N-1:0]     firm;
    logic [N-1:0]     spec;
    logic [N-1:0]     tent;
    logic [N-1:0]     kept;
    logic [N-1:0]     rel;
    logic [NPORT-1:0] adv_in;

    // Classify each input VC: no bid until the route is known.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            bid[i] = BID_NONE;
            if (in_flit_vld[i] && in_route_vld[i]) begin
                bid[i] = in_has_vc[i] ? BID_FIRM : BID_SPEC;
            end
            firm[i] = (bid[i] == BID_FIRM);
            spec[i] = (bid[i] == BID_SPEC);
        end
    end

    ovc_alloc #(.NPORT(NPORT), .NVC(NVC)) u_ovc (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_req     (spec),
        .head_port    (in_out_port),
        .release_mask (rel),
        .vc_gnt       (vc_gnt),
        .vc_gnt_id    (vc_gnt_id),
        .free_mask    (ovc_free)
    );

    sw_alloc #(.NPORT(NPORT), .NVC(NVC)) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .firm    (firm),
        .spec    (spec),
        .dest    (in_out_port),
        .adv_in  (adv_in),
        .adv_out (xb_vld),
        .tent    (tent)
    );

    // Keep firm wins and speculative wins backed by a VC; drive the crossbar.
    always_comb begin
        kept   = '0;
        xb_vld = '0;
        xb_sel = '0;
        adv_in = '0;
        rel    = '0;
        for (int i = 0; i < N; i++) begin
            kept[i] = tent[i] && (firm[i] || vc_gnt[i]);
            if (kept[i]) begin
                xb_vld[in_out_port[i*PW +: PW]]                  = 1'b1;
                xb_sel[int'(in_out_port[i*PW +: PW])*PW +: PW]   = PW'(i / NVC);
                adv_in[i / NVC]                                  = 1'b1;
                if (in_tail[i]) begin
                    rel[int'(in_out_port[i*PW +: PW])*NVC
                        + int'(firm[i] ? in_held_vc[i*VW +: VW] : vc_gnt_id[i*VW +: VW])] = 1'b1;
                end
            end
        end
    end

    assign sw_gnt = kept;

    // Checks on the combined behaviour, written against the ports.
    logic [idx_w(N)-1:0] gidx [N];
    always_comb begin
        for (int i = 0; i < N; i++) begin
            gidx[i] = idx_w(N)'(int'(in_out_port[i*PW +: PW])*NVC + int'(vc_gnt_id[i*VW +: VW]));
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_route_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (vc_gnt[i] || sw_gnt[i]) |-> (in_flit_vld[i] && in_route_vld[i]));

        p_spec_needs_vc_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_gnt[i] && !in_has_vc[i]) |-> vc_gnt[i]);

        p_firm_first_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_gnt[i] && !in_has_vc[i]) |-> !(|firm[(i/NVC)*NVC +: NVC]));

        p_owner_no_new_vc_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_has_vc[i] |-> !vc_gnt[i]);

        p_granted_vc_was_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
            vc_gnt[i] |-> ovc_free[gidx[i]]);

        p_granted_vc_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (vc_gnt[i] && !(sw_gnt[i] && in_tail[i])) |=> !ovc_free[$past(gidx[i])]);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_chk_port
        p_one_grant_per_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(sw_gnt[p*NVC +: NVC]));
    end

    p_one_input_per_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_gnt) == $countones(xb_vld));

endmodule

// File: tb/test_spec_vc_sw_alloc.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spec_vc_sw_alloc;

    localparam int NPORT = 4;
    localparam int NVC   = 2;
    localparam int N     = NPORT * NVC;
    localparam int PW    = 2;
    localparam int VW    = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_flit_vld;
    logic [N-1:0]      in_route_vld;
    logic [N*PW-1:0]   in_out_port;
    logic [N-1:0]      in_has_vc;
    logic [N*VW-1:0]   in_held_vc;
    logic [N-1:0]      in_tail;
    logic [N-1:0]      vc_gnt;
    logic [N*VW-1:0]   vc_gnt_id;
    logic [N-1:0]      sw_gnt;
    logic [NPORT-1:0]  xb_vld;
    logic [NPORT*PW-1:0] xb_sel;
    logic [N-1:0]      ovc_free;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spec_vc_sw_alloc #(.NPORT(NPORT), .NVC(NVC)) i_spec_vc_sw_alloc (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_flit_vld  (in_flit_vld),
        .in_route_vld (in_route_vld),
        .in_out_port  (in_out_port),
        .in_has_vc    (in_has_vc),
        .in_held_vc   (in_held_vc),
        .in_tail      (in_tail),
        .vc_gnt       (vc_gnt),
        .vc_gnt_id    (vc_gnt_id),
        .sw_gnt       (sw_gnt),
        .xb_vld       (xb_vld),
        .xb_sel       (xb_sel),
        .ovc_free     (ovc_free)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        in_flit_vld  = '0;
        in_route_vld = '0;
        in_out_port  = '0;
        in_has_vc    = '0;
        in_held_vc   = '0;
        in_tail      = '0;
    endtask

    task automatic put(input int i, input int port, input bit hv, input int held,
                       input bit tl, input bit rv = 1'b1);
        in_flit_vld[i]            = 1'b1;
        in_route_vld[i]           = rv;
        in_out_port[i*PW +: PW]   = PW'(port);
        in_has_vc[i]              = hv;
        in_held_vc[i*VW +: VW]    = VW'(held);
        in_tail[i]                = tl;
    endtask

    // Start a cycle: drive after the falling edge.
    task automatic cyc();
        @(negedge clk);
        clear_req();
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_req();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        cyc(); #4;
        chk("R8 reset free map", 32'(ovc_free), 32'hFF);
        chk("R8 reset vc_gnt", 32'(vc_gnt), 32'h0);
        chk("R8 reset sw_gnt", 32'(sw_gnt), 32'h0);
        chk("R8 reset xb_vld", 32'(xb_vld), 32'h0);
    endtask

    task automatic t_route();
        do_reset();
        cyc(); put(0, 1, 0, 0, 0, 1'b0); #4;
        chk("R1 no route vc_gnt", 32'(vc_gnt), 32'h0);
        chk("R1 no route sw_gnt", 32'(sw_gnt), 32'h0);
        chk("R1 no route xb_vld", 32'(xb_vld), 32'h0);
        cyc(); put(0, 1, 0, 0, 0); #4;
        chk("R2 vc_gnt same cycle", 32'(vc_gnt), 32'h01);
        chk("R2 sw_gnt same cycle", 32'(sw_gnt), 32'h01);
        chk("R11 xb_vld", 32'(xb_vld), 32'h2);
        chk("R11 xb_sel out1", 32'(xb_sel[3:2]), 32'd0);
        cyc(); #4;
        chk("R8 busy after grant", 32'(ovc_free), 32'hFB);
    endtask

    task automatic t_spec_drop();
        do_reset();
        cyc(); put(0, 3, 0, 0, 0); #4;
        chk("R10 first vc id", 32'(vc_gnt_id[0]), 32'd0);
        chk("R3 spec kept xb_vld", 32'(xb_vld), 32'h8);
        cyc(); put(2, 3, 0, 0, 0); #4;
        chk("R8 vc0 busy", 32'(ovc_free), 32'hBF);
        chk("R10 second vc id", 32'(vc_gnt_id[2]), 32'd1);
        chk("R3 second spec kept", 32'(sw_gnt), 32'h04);
        cyc(); put(4, 3, 0, 0, 0); #4;
        chk("R8 both busy", 32'(ovc_free), 32'h3F);
        chk("R3 no vc no vc_gnt", 32'(vc_gnt), 32'h0);
        chk("R3 spec win dropped", 32'(sw_gnt), 32'h0);
        chk("R3 output idle", 32'(xb_vld), 32'h0);
        cyc(); put(0, 3, 1, 0, 1); put(4, 3, 0, 0, 0); #4;
        chk("R4 failed bid left map", 32'(ovc_free), 32'h3F);
        chk("R5 firm tail wins", 32'(sw_gnt), 32'h01);
        chk("R5 xb_sel out3", 32'(xb_sel[7:6]), 32'd0);
        cyc(); put(4, 3, 0, 0, 0); #4;
        chk("R6 tail released vc0", 32'(ovc_free), 32'h7F);
        chk("R4 retry vc_gnt", 32'(vc_gnt), 32'h10);
        chk("R4 retry vc id", 32'(vc_gnt_id[4]), 32'd0);
        chk("R4 retry sw_gnt", 32'(sw_gnt), 32'h10);
        chk("R4 retry xb_sel", 32'(xb_sel[7:6]), 32'd2);
    endtask

    task automatic t_priority();
        do_reset();
        cyc();
        put(2, 1, 1, 1, 0); put(0, 1, 0, 0, 0);
        put(4, 2, 0, 0, 0); put(5, 0, 1, 0, 0);
        #4;
        chk("R5 vc_gnt parallel", 32'(vc_gnt), 32'h11);
        chk("R5 firm beats spec", 32'(sw_gnt), 32'h24);
        chk("R9 xb_vld", 32'(xb_vld), 32'h3);
        chk("R5 out0 from port2", 32'(xb_sel[1:0]), 32'd2);
        chk("R5 out1 from port1", 32'(xb_sel[3:2]), 32'd1);
        cyc(); #4;
        chk("R6 firm no claim", 32'(ovc_free), 32'hEB);
    endtask

    task automatic t_rr();
        do_reset();
        cyc(); put(0, 2, 1, 0, 0); put(2, 2, 1, 1, 0); #4;
        chk("R7 rr first", 32'(xb_sel[5:4]), 32'd0);
        cyc(); put(0, 2, 1, 0, 0); put(2, 2, 1, 1, 0); #4;
        chk("R7 rr second", 32'(xb_sel[5:4]), 32'd1);
        chk("R7 rr second sw", 32'(sw_gnt), 32'h04);
        cyc(); put(0, 2, 1, 0, 0); put(2, 2, 1, 1, 0); #4;
        chk("R7 rr wraps", 32'(xb_sel[5:4]), 32'd0);
        chk("R6 firm leaves map", 32'(ovc_free), 32'hFF);
        do_reset();
        cyc(); put(4, 2, 0, 0, 0); #4;
        cyc(); put(6, 2, 0, 0, 0); #4;
        chk("R10 lowest free", 32'(vc_gnt_id[6]), 32'd1);
        cyc(); put(0, 2, 0, 0, 0); #4;
        chk("R3 dropped spec", 32'(sw_gnt), 32'h0);
        cyc(); put(0, 2, 1, 0, 0); put(2, 2, 1, 1, 0); #4;
        chk("R7 drop kept pointer", 32'(xb_sel[5:4]), 32'd0);
        chk("R7 drop kept pointer sw", 32'(sw_gnt), 32'h01);
    endtask

    task automatic t_one_per_port();
        do_reset();
        cyc(); put(0, 1, 1, 0, 0); put(1, 2, 1, 0, 0); #4;
        chk("R9 one grant per input", 32'(sw_gnt), 32'h01);
        chk("R9 one output driven", 32'(xb_vld), 32'h2);
        cyc(); put(0, 1, 1, 0, 0); put(1, 2, 1, 0, 0); #4;
        chk("R7 input rr moves", 32'(sw_gnt), 32'h02);
        chk("R9 other output", 32'(xb_vld), 32'h4);
        chk("R11 xb_sel out2", 32'(xb_sel[5:4]), 32'd0);
    endtask

    task automatic t_single();
        do_reset();
        cyc(); put(6, 0, 0, 0, 1); #4;
        chk("R8 single vc_gnt", 32'(vc_gnt), 32'h40);
        chk("R8 single sw_gnt", 32'(sw_gnt), 32'h40);
        chk("R11 out0 from port3", 32'(xb_sel[1:0]), 32'd3);
        cyc(); put(6, 0, 0, 0, 0); #4;
        chk("R8 single flit left free", 32'(ovc_free), 32'hFF);
        chk("R8 head vc_gnt", 32'(vc_gnt), 32'h40);
        cyc(); put(6, 0, 1, 0, 0); #4;
        chk("R8 head holds vc", 32'(ovc_free), 32'hFE);
        chk("R6 body no vc_gnt", 32'(vc_gnt), 32'h0);
        chk("R6 body sw_gnt", 32'(sw_gnt), 32'h40);
        cyc(); put(6, 0, 1, 0, 1); #4;
        chk("R6 body keeps vc", 32'(ovc_free), 32'hFE);
        chk("R6 tail sw_gnt", 32'(sw_gnt), 32'h40);
        cyc(); #4;
        chk("R8 tail frees vc", 32'(ovc_free), 32'hFF);
    endtask

    task automatic t_lowest();
        do_reset();
        cyc(); put(0, 1, 0, 0, 0); #4;
        cyc(); put(2, 1, 0, 0, 0); put(4, 1, 0, 0, 0); #4;
        chk("R8 vc0 of out1 busy", 32'(ovc_free), 32'hFB);
        chk("R10 one vc per port", 32'(vc_gnt), 32'h04);
        chk("R10 next free id", 32'(vc_gnt_id[2]), 32'd1);
        chk("R3 kept for vc winner", 32'(sw_gnt), 32'h04);
        chk("R7 out1 rr", 32'(xb_sel[3:2]), 32'd1);
        cyc(); put(4, 1, 0, 0, 0); #4;
        chk("R10 port full", 32'(ovc_free), 32'hF3);
        chk("R10 no vc when full", 32'(vc_gnt), 32'h0);
        chk("R3 no sw when full", 32'(sw_gnt), 32'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        clear_req();
        t_reset();
        t_route();
        t_spec_drop();
        t_priority();
        t_rr();
        t_one_per_port();
        t_single();
        t_lowest();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 actual=timeout expected=finished");
        finish_run();
    end

endmodule